// File: doc/BRIEF.md
# DRAM Start-up and Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and keeps it refreshed. Once reset is released it stays silent for a programmable power-up pause. It then runs a fixed number of wake-up refresh cycles and raises `ready_o`. From that point on an interval timer produces one refresh request per refresh period. Every refresh is a CAS-before-RAS cycle, so the block never drives the address bus.

The block does not own the memory pins permanently; the access controller does. When the sequencer needs a refresh it raises `ref_req_o`. The controller answers with `ref_gnt_i` when the bus is free. While `bus_own_o` is high, the sequencer's RAS, CAS and W strobes are the ones to route to the memory. A long page access can hold off the grant. For that case, requests that arrive during the hold-off are counted up to a small bound and drained back to back once the grant comes. If the bound is exceeded, a sticky error flag is set.

All timing is given in clock cycles through parameters: the pause, the refresh period, CAS set-up ahead of RAS, CAS hold after RAS falls, RAS low time, precharge, and a leading idle slot that keeps CAS high before it falls.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is asserted, and for exactly PAUSE_CYC clock cycles after it is released, `ready_o`, `ref_req_o`, `bus_own_o` and `pend_ovf_o` are 0 and `ras_n_o`, `cas_n_o`, `we_n_o` are 1.
- R2: After the pause, exactly WAKE_CNT refresh cycles are completed before `ready_o` rises. `ready_o` rises only while the bus is released and then stays 1 until reset.
- R3: In each refresh cycle, CAS falls exactly CSR_CYC cycles before RAS falls. CAS stays low for exactly CHR_CYC cycles counted from the RAS fall, then returns high while RAS is still low.
- R4: `we_n_o` is 1 in every cycle, including the whole of every refresh cycle.
- R5: RAS stays low for exactly RAS_CYC cycles. It is followed by exactly RP_CYC cycles of precharge with RAS and CAS high, during which the bus is still owned.
- R6: Each owned cycle opens with exactly RPC_CYC cycles in which RAS and CAS are both high, before CAS falls.
- R7: `ref_req_o` is 1 only while the bus is released and a refresh is owed. A cycle starts on the clock edge at which `ref_req_o` and `ref_gnt_i` are both 1. `bus_own_o` is 1 from the next cycle for RPC_CYC+CSR_CYC+RAS_CYC+RP_CYC cycles, and `ref_req_o` is 0 throughout.
- R8: Once ready, a refresh is owed every INTERVAL_CYC cycles. The first request appears INTERVAL_CYC cycles after `ready_o` is first seen high, and with an immediate grant the requests rise exactly INTERVAL_CYC cycles apart.
- R9: Refreshes owed while the grant is withheld are kept, up to PEND_MAX. `ref_req_o` stays 1 while any are kept. On grant they are performed back to back, exactly PEND_MAX cycles when the count is full.
- R10: A refresh period that ends while PEND_MAX refreshes are already owed and none is starting sets `pend_ovf_o`. The count stays at PEND_MAX and the flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_o | output | 1 | Memory initialised and usable |
| ref_req_o | output | 1 | Refresh cycle wanted |
| ref_gnt_i | input | 1 | Access controller hands over the bus |
| bus_own_o | output | 1 | Sequencer strobes are valid on the memory |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |
| pend_ovf_o | output | 1 | Sticky overflow of owed refreshes |

## Verification
The embedded properties check the rules that hold on every cycle: CAS is already low at and just before each RAS fall; CAS falls only with RAS high; no request is raised while the bus is owned; the owed count stays within its bound; and the ready and overflow flags never drop. The bench's scenarios cover what needs a count over a window: the exact pause length, the number of wake-up cycles, the cycle-exact strobe shape of every refresh checked against a scoreboard, the spacing of periodic requests, saturation and back-to-back drain after a withheld grant, and the moment the overflow flag rises.

// File: rtl/drf_pkg.sv
package drf_pkg;

  typedef enum logic [1:0] {BT_PAUSE, BT_WAKE, BT_RUN} boot_t;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_CASLO, PH_RASLO, PH_PRECH} phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Length in cycles of each owned phase of a refresh cycle.
  function automatic int ph_len(input phase_t p, input int rpc, input int csr,
                                input int ras, input int rp);
    case (p)
      PH_SETUP: return rpc;
      PH_CASLO: return csr;
      PH_RASLO: return ras;
      PH_PRECH: return rp;
      default:  return 1;
    endcase
  endfunction

  function automatic phase_t ph_next(input phase_t p);
    case (p)
      PH_SETUP: return PH_CASLO;
      PH_CASLO: return PH_RASLO;
      PH_RASLO: return PH_PRECH;
      default:  return PH_IDLE;
    endcase
  endfunction

  // CAS is low from its set-up phase until chr cycles into the RAS-low phase.
  function automatic logic cas_active(input phase_t p, input int cnt, input int chr);
    return (p == PH_CASLO) || ((p == PH_RASLO) && (cnt < chr));
  endfunction

endpackage

// File: rtl/drf_tick.sv
module drf_tick #(
  parameter int INTERVAL_CYC = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYC);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R8: period ends are isolated single-cycle events
  a_r8_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/drf_pend.sv
module drf_pend #(
  parameter int PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_nz_o,
  output logic ovf_o
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] cnt_q;
  logic          full_w;

  assign full_w    = (cnt_q == PW'(PEND_MAX));
  assign pend_nz_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      case ({inc_i, dec_i})
        2'b10: if (full_w) ovf_o <= 1'b1; else cnt_q <= cnt_q + 1'b1;
        2'b01: cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  a_r9_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PW'(PEND_MAX));
  a_r9_dec_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> pend_nz_o);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

endmodule

// File: rtl/drf_cbr_seq.sv
module drf_cbr_seq
  import drf_pkg::*;
#(
  parameter int RPC_CYC = 1,
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 9,
  parameter int RP_CYC  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int LMAX = max_of(max_of(RPC_CYC, CSR_CYC), max_of(RAS_CYC, RP_CYC));
  localparam int CW   = $clog2(LMAX + 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w  = (ph_q != PH_IDLE) &&
                   (int'(cnt_q) == ph_len(ph_q, RPC_CYC, CSR_CYC, RAS_CYC, RP_CYC) - 1);
  assign busy_o  = (ph_q != PH_IDLE);
  assign ras_n_o = (ph_q != PH_RASLO);
  assign cas_n_o = !cas_active(ph_q, int'(cnt_q), CHR_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      cnt_q <= '0;
      if (start_i) ph_q <= PH_SETUP;
    end else if (last_w) begin
      ph_q  <= ph_next(ph_q);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));
  a_r6_cas_falls_in_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> ras_n_o);
  a_r7_start_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
  import drf_pkg::*;
#(
  parameter int PAUSE_CYC    = 40000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 3120,
  parameter int PEND_MAX     = 3,
  parameter int RPC_CYC      = 1,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 9,
  parameter int RP_CYC       = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o,
  output logic ref_req_o,
  input  logic ref_gnt_i,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic pend_ovf_o
);
  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam int WW  = $clog2(WAKE_CNT + 1);

  boot_t          st_q;
  logic [PCW-1:0] pcnt_q;
  logic [WW-1:0]  wake_left_q;
  logic           seq_busy, tick, pend_nz, start, in_pause;

  assign in_pause  = (st_q == BT_PAUSE);
  assign ready_o   = (st_q == BT_RUN);
  assign ref_req_o = !seq_busy &&
                     (((st_q == BT_WAKE) && (wake_left_q != '0)) ||
                      ((st_q == BT_RUN) && pend_nz));
  assign start     = ref_req_o && ref_gnt_i;
  assign bus_own_o = seq_busy;
  assign we_n_o    = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= BT_PAUSE;
      pcnt_q      <= '0;
      wake_left_q <= WW'(WAKE_CNT);
    end else begin
      case (st_q)
        BT_PAUSE: begin
          if (pcnt_q == PCW'(PAUSE_CYC - 1)) st_q <= BT_WAKE;
          else                               pcnt_q <= pcnt_q + 1'b1;
        end
        BT_WAKE: begin
          if (start) wake_left_q <= wake_left_q - 1'b1;
          else if ((wake_left_q == '0) && !seq_busy) st_q <= BT_RUN;
        end
        default: ;
      endcase
    end
  end

  drf_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(ready_o), .tick_o(tick));

  drf_pend #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(start && ready_o),
    .pend_nz_o(pend_nz), .ovf_o(pend_ovf_o));

  drf_cbr_seq #(.RPC_CYC(RPC_CYC), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
                .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(seq_busy),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o));

  a_r1_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (!ref_req_o && !bus_own_o && ras_n_o && cas_n_o));
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  a_r2_ready_with_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !bus_own_o);
  a_r7_no_req_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own_o |-> !ref_req_o);

endmodule

// File: tb/tb_dram_refresh_sequencer.sv
`timescale 1ns/1ps
module tb_dram_refresh_sequencer;
  localparam int PAUSE = 300, WAKE = 8, INTV = 80, PMAX = 3;
  localparam int RPC = 1, CSR = 1, CHR = 2, RASL = 9, RP = 7;

  typedef struct { int setup; int csr; int chr; int rasl; int rp; } shape_t;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b1;
  logic ready, req, own, ras_n, cas_n, we_n, ovf;
  int cyc = 0, n_tests = 0, n_fail = 0, done_cnt = 0, we_bad = 0;
  bit finished = 1'b0;
  shape_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sequencer #(.PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV),
    .PEND_MAX(PMAX), .RPC_CYC(RPC), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASL),
    .RP_CYC(RP)) dut (
    .clk(clk), .rst_n(rst_n), .ready_o(ready), .ref_req_o(req), .ref_gnt_i(gnt),
    .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .pend_ovf_o(ovf));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic push_expect();
    shape_t s;
    s.setup = RPC; s.csr = CSR; s.chr = CHR; s.rasl = RASL; s.rp = RP;
    sb_q.push_back(s);
  endtask

  task automatic set_gnt(input logic v);
    @(posedge clk); #1 gnt = v;
  endtask

  task automatic wait_to(input int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  // driver side: every accepted grant promises one refresh of the required shape
  always @(negedge clk) if (rst_n && req && gnt) push_expect();

  // monitor: measure each owned window, pop and compare
  shape_t m = '{0, 0, 0, 0, 0};
  bit in_cyc = 1'b0, ras_seen = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (we_n !== 1'b1) we_bad++;
    if (own) begin
      in_cyc = 1'b1;
      if (req) chk("R7", "request while owned", 1, 0);
      if (!ras_n) begin ras_seen = 1'b1; m.rasl++; if (!cas_n) m.chr++; end
      else if (ras_seen) begin m.rp++; if (!cas_n) chk("R5", "CAS low in precharge", 0, 1); end
      else if (cas_n) m.setup++;
      else m.csr++;
    end else if (in_cyc) begin
      shape_t e;
      done_cnt++;
      if (sb_q.size() == 0) chk("R7", "cycle without grant", 1, 0);
      else begin
        e = sb_q.pop_front();
        chk("R6", "idle lead-in", m.setup, e.setup);
        chk("R3", "CAS set-up", m.csr, e.csr);
        chk("R3", "CAS hold after RAS", m.chr, e.chr);
        chk("R5", "RAS low", m.rasl, e.rasl);
        chk("R5", "precharge", m.rp, e.rp);
      end
      m = '{0, 0, 0, 0, 0}; in_cyc = 1'b0; ras_seen = 1'b0;
    end
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, n0, d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset ready/req/own", {ready, req, own, ovf}, 0);
    chk("R1", "reset strobes", {ras_n, cas_n, we_n}, 7);
    @(posedge clk); #1 rst_n = 1'b1; r0 = cyc;
    @(negedge clk);
    while (!req) begin
      if (own || ready || !ras_n || !cas_n) chk("R1", "activity in pause", 1, 0);
      @(negedge clk);
    end
    chk("R1", "pause length", cyc - r0, PAUSE);
    while (!ready) @(negedge clk);
    chk("R2", "wake-up cycles", done_cnt, WAKE);
    chk("R2", "bus free at ready", own, 0);
    n0 = cyc;
    wait_to(n0 + INTV - 1);
    chk("R8", "no request before period", req, 0);
    @(negedge clk);
    chk("R8", "first request", req, 1);
    wait_to(n0 + 2 * INTV - 1);
    chk("R8", "second request early", req, 0);
    @(negedge clk);
    chk("R8", "second request", req, 1);
    set_gnt(1'b0);
    wait_to(n0 + 3 * INTV + 2);
    chk("R9", "owed refresh held", req, 1);
    chk("R9", "no cycle without grant", own, 0);
    wait_to(n0 + 6 * INTV - 3);
    chk("R10", "no overflow at bound", ovf, 0);
    wait_to(n0 + 6 * INTV + 3);
    chk("R10", "overflow flagged", ovf, 1);
    d0 = done_cnt;
    set_gnt(1'b1);
    wait_to(n0 + 7 * INTV - 3);
    chk("R9", "back-to-back drain", done_cnt - d0, PMAX);
    chk("R9", "nothing left owed", req, 0);
    wait_to(n0 + 7 * INTV);
    chk("R8", "period resumes", req, 1);
    wait_to(n0 + 7 * INTV + 30);
    chk("R10", "overflow sticky", ovf, 1);
    chk("R2", "ready holds", ready, 1);
    chk("R4", "W high every cycle", we_bad, 0);
    chk("R7", "scoreboard empty", sb_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule